// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches for a stalled system by comparing a shared 64-bit free-running system counter against an absolute deadline held in a compare register. Software starts the timer and then refreshes it at regular intervals. Each refresh moves the deadline to the current counter value plus a programmable 32-bit offset. If the deadline passes without a refresh, a first-stage output rises, which is intended to drive an interrupt. The compare register then advances by one more offset. If that second deadline also passes, a second-stage output rises, which is intended to request a system reset.

Registers are reached over a simple single-cycle register bus. The bus carries a frame select that chooses between a control frame and a refresh frame. Any write to the refresh word refreshes the timer. A write to the control word also refreshes it, and so does a write to the offset word while the timer runs. Two reset inputs are provided. The warm reset clears every register except the second-stage flag. The power-on reset clears everything. As a result, the reason for the last reset can still be read after the block restarts.

Top module: `wdt_top`

## Requirements
- R1: After power-on reset, both stage outputs are low and every readable register, including control status, offset and compare, reads 0.
- R2: Reads return data on `rdData` one cycle after `rdEn` is sampled. Control frame (`frameSel`=0) map: 0x000 status {bit2 stage-2 flag, bit1 stage-1 flag, bit0 enable}, 0x008 offset, 0x010 compare low word, 0x014 compare high word. Both frames return `IMPL_ID` at 0xFCC and `IDENT` at 0xFD0. Every other address reads 0.
- R3: A write to control 0x000 sets enable to wdata bit 0. The same write is a refresh: compare becomes counter + offset and both stage flags clear.
- R4: A write of any data to refresh-frame (`frameSel`=1) address 0x000 is a refresh.
- R5: A write to control 0x008 stores the offset. While enabled, it is also a refresh that uses the new offset. While disabled, compare is unchanged.
- R6: While enabled, with the stage-1 flag clear and counter >= compare (unsigned), the stage-1 flag sets at that clock edge and compare advances by the offset.
- R7: While enabled, with the stage-1 flag set and counter >= compare, the stage-2 flag sets. Stage 2 never rises unless stage 1 was already set.
- R8: Stage outputs are levels equal to the flags. They hold until a refresh. While disabled, no flag changes, whatever the counter value.
- R9: The warm reset `rstN` does not clear the stage-2 flag. Only the power-on reset or a refresh clears it.
- R10: Writes to control 0x010 and 0x014 load the compare low and high words directly, without a refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, asynchronous, active low; clears all state |
| rstN | input | 1 | Warm reset, asynchronous, active low; keeps the stage-2 flag |
| sysCount | input | 64 | Free-running system counter |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| frameSel | input | 1 | 0 = control frame, 1 = refresh frame |
| addr | input | 12 | Byte offset within the frame |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| stage1Out | output | 1 | First-stage timeout level (interrupt request) |
| stage2Out | output | 1 | Second-stage timeout level (reset request) |

## Verification
The bound checker checks the cycle-level rules on every clock. Stage 1 rises only while enabled and with the counter at or past the deadline. Stage 2 rises only after stage 1. A refresh-frame write clears both outputs on the next cycle. A disabled, idle timer holds its outputs. The bench scenarios cover the behaviour that needs values or history to judge: the exact compare arithmetic after each refresh source, the one-count boundary at the deadline, the split writes of the compare halves, the register map, and the survival of the stage-2 flag across a warm reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_STATUS  = 12'h000;
  localparam logic [ADDR_W-1:0] A_OFFSET  = 12'h008;
  localparam logic [ADDR_W-1:0] A_CMP_LO  = 12'h010;
  localparam logic [ADDR_W-1:0] A_CMP_HI  = 12'h014;
  localparam logic [ADDR_W-1:0] A_IMPL    = 12'hFCC;
  localparam logic [ADDR_W-1:0] A_IDENT   = 12'hFD0;
  localparam logic [ADDR_W-1:0] A_REFRESH = 12'h000;

  localparam logic FRAME_CTRL    = 1'b0;
  localparam logic FRAME_REFRESH = 1'b1;

  typedef struct packed {
    logic refresh;
    logic wrEnable;
    logic wrOffset;
    logic wrCmpLo;
    logic wrCmpHi;
  } strobe_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W = 64,
  parameter logic [DATA_W-1:0] IMPL_ID = '0,
  parameter logic [DATA_W-1:0] IDENT = '0
) (
  input  logic              clk,
  input  logic              anyRstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              frameSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              enQ,
  input  logic              ws0Q,
  input  logic              ws1Q,
  input  logic [DATA_W-1:0] offsetQ,
  input  logic [CNT_W-1:0]  cmpQ,
  output strobe_t           strb,
  output logic [DATA_W-1:0] rdData
);
  localparam int HALF_W = CNT_W / 2;

  logic ctrlWr, refWr;
  logic [DATA_W-1:0] rdNext;

  assign ctrlWr = wrEn && (frameSel == FRAME_CTRL);
  assign refWr  = wrEn && (frameSel == FRAME_REFRESH);

  always_comb begin
    strb.wrEnable = ctrlWr && (addr == A_STATUS);
    strb.wrOffset = ctrlWr && (addr == A_OFFSET);
    strb.wrCmpLo  = ctrlWr && (addr == A_CMP_LO);
    strb.wrCmpHi  = ctrlWr && (addr == A_CMP_HI);
    strb.refresh  = strb.wrEnable
                  || (refWr && (addr == A_REFRESH))
                  || (strb.wrOffset && enQ);
  end

  always_comb begin
    rdNext = '0;
    if (addr == A_IMPL) begin
      rdNext = IMPL_ID;
    end else if (addr == A_IDENT) begin
      rdNext = IDENT;
    end else if (frameSel == FRAME_CTRL) begin
      case (addr)
        A_STATUS: rdNext = {{(DATA_W-3){1'b0}}, ws1Q, ws0Q, enQ};
        A_OFFSET: rdNext = offsetQ;
        A_CMP_LO: rdNext = DATA_W'(cmpQ[HALF_W-1:0]);
        A_CMP_HI: rdNext = DATA_W'(cmpQ[CNT_W-1:HALF_W]);
        default:  rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN) begin
      rdData <= '0;
    end else if (rdEn) begin
      rdData <= rdNext;
    end
  end
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W = 64
) (
  input  logic              clk,
  input  logic              anyRstN,
  input  logic              porN,
  input  logic [CNT_W-1:0]  sysCount,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  output logic              enQ,
  output logic              ws0Q,
  output logic              ws1Q,
  output logic [DATA_W-1:0] offsetQ,
  output logic [CNT_W-1:0]  cmpQ
);
  localparam int HALF_W = CNT_W / 2;

  logic [DATA_W-1:0] loadOff;
  logic              hit;
  logic              cmpWr;

  assign loadOff = strb.wrOffset ? wrData : offsetQ;
  assign hit     = sysCount >= cmpQ;
  assign cmpWr   = strb.wrCmpLo || strb.wrCmpHi;

  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN) begin
      enQ     <= 1'b0;
      offsetQ <= '0;
      cmpQ    <= '0;
      ws0Q    <= 1'b0;
    end else begin
      if (strb.wrEnable) enQ <= wrData[0];
      if (strb.wrOffset) offsetQ <= wrData;
      if (strb.refresh) begin
        cmpQ <= sysCount + CNT_W'(loadOff);
        ws0Q <= 1'b0;
      end else if (cmpWr) begin
        if (strb.wrCmpLo) cmpQ[HALF_W-1:0] <= HALF_W'(wrData);
        if (strb.wrCmpHi) cmpQ[CNT_W-1:HALF_W] <= HALF_W'(wrData);
      end else if (enQ && hit && !ws0Q) begin
        ws0Q <= 1'b1;
        cmpQ <= cmpQ + CNT_W'(offsetQ);
      end
    end
  end

  // stage-2 flag lives on the power-on reset only
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      ws1Q <= 1'b0;
    end else if (strb.refresh) begin
      ws1Q <= 1'b0;
    end else if (!cmpWr && enQ && hit && ws0Q) begin
      ws1Q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W = 64,
  parameter logic [31:0] IMPL_ID = 32'h0001_0A5B,
  parameter logic [31:0] IDENT = 32'h5744_0001
) (
  input  logic        clk,
  input  logic        porN,
  input  logic        rstN,
  input  logic [63:0] sysCount,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic        frameSel,
  input  logic [11:0] addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        stage1Out,
  output logic        stage2Out
);
  logic              anyRstN;
  strobe_t           strb;
  logic              enQ, ws0Q, ws1Q;
  logic [DATA_W-1:0] offsetQ;
  logic [CNT_W-1:0]  cmpQ;

  assign anyRstN = porN && rstN;

  wdt_ctrl #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .IMPL_ID(IMPL_ID), .IDENT(IDENT)
  ) u_ctrl (
    .clk(clk), .anyRstN(anyRstN), .wrEn(wrEn), .rdEn(rdEn),
    .frameSel(frameSel), .addr(addr), .enQ(enQ), .ws0Q(ws0Q), .ws1Q(ws1Q),
    .offsetQ(offsetQ), .cmpQ(cmpQ), .strb(strb), .rdData(rdData)
  );

  wdt_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .anyRstN(anyRstN), .porN(porN), .sysCount(sysCount),
    .strb(strb), .wrData(wrData), .enQ(enQ), .ws0Q(ws0Q), .ws1Q(ws1Q),
    .offsetQ(offsetQ), .cmpQ(cmpQ)
  );

  assign stage1Out = ws0Q;
  assign stage2Out = ws1Q;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic        clk,
  input logic        porN,
  input logic        rstN,
  input logic [63:0] sysCount,
  input logic [63:0] cmpQ,
  input logic        enQ,
  input logic        wrEn,
  input logic        frameSel,
  input logic [11:0] addr,
  input logic        stage1Out,
  input logic        stage2Out
);
  assert_stage1_cause_R6: assert property (@(posedge clk) disable iff (!porN || !rstN)
    $rose(stage1Out) |-> ($past(enQ) && ($past(sysCount) >= $past(cmpQ))));

  assert_stage2_order_R7: assert property (@(posedge clk) disable iff (!porN || !rstN)
    $rose(stage2Out) |-> ($past(stage1Out) && $past(enQ)));

  assert_refresh_clears_R4: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (wrEn && frameSel && addr == 12'h000) |=> (!stage1Out && !stage2Out));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (!enQ && !wrEn) |=> ($stable(stage1Out) && $stable(stage2Out)));
endmodule

bind wdt_top wdt_checker u_chk (
  .clk(clk), .porN(porN), .rstN(rstN), .sysCount(sysCount), .cmpQ(cmpQ),
  .enQ(enQ), .wrEn(wrEn), .frameSel(frameSel), .addr(addr),
  .stage1Out(stage1Out), .stage2Out(stage2Out)
);

// File: tb/sim_wdt_top.sv
module sim_wdt_top;
  localparam logic [31:0] IMPL = 32'h0001_0A5B;
  localparam logic [31:0] IDV  = 32'h5744_0001;
  localparam int NV = 34;
  // kind(2) req(4) frame(1) addr(12) data(32) exp(32)
  localparam int VW = 83;
  localparam logic [1:0] WR = 2'd0, RD = 2'd1, CN = 2'd2;

  localparam logic [VW-1:0] VEC [NV] = '{
    {RD, 4'd1,  1'b0, 12'h000, 32'd0,          32'd0},  // R1
    {RD, 4'd2,  1'b0, 12'hFCC, 32'd0,          IMPL},   // R2
    {RD, 4'd2,  1'b1, 12'hFD0, 32'd0,          IDV},    // R2
    {CN, 4'd8,  1'b0, 12'h000, 32'd100,        32'd0},  // R8 disabled
    {WR, 4'd5,  1'b0, 12'h008, 32'd50,         32'd0},  // R5
    {RD, 4'd5,  1'b0, 12'h010, 32'd0,          32'd0},  // R5 no refresh
    {RD, 4'd5,  1'b0, 12'h008, 32'd0,          32'd50},
    {WR, 4'd3,  1'b0, 12'h000, 32'd1,          32'd0},  // R3 enable
    {RD, 4'd3,  1'b0, 12'h010, 32'd0,          32'd150},
    {RD, 4'd3,  1'b0, 12'h014, 32'd0,          32'd0},
    {RD, 4'd3,  1'b0, 12'h000, 32'd0,          32'd1},
    {CN, 4'd6,  1'b0, 12'h000, 32'd149,        32'd0},  // R6 boundary
    {CN, 4'd6,  1'b0, 12'h000, 32'd150,        32'd1},  // R6
    {RD, 4'd6,  1'b0, 12'h010, 32'd0,          32'd200},
    {RD, 4'd6,  1'b0, 12'h000, 32'd0,          32'd3},
    {CN, 4'd8,  1'b0, 12'h000, 32'd199,        32'd1},  // R8 level
    {WR, 4'd4,  1'b1, 12'h000, 32'hDEADBEEF,   32'd0},  // R4
    {RD, 4'd4,  1'b0, 12'h000, 32'd0,          32'd1},
    {RD, 4'd4,  1'b0, 12'h010, 32'd0,          32'd249},
    {CN, 4'd6,  1'b0, 12'h000, 32'd249,        32'd1},
    {CN, 4'd7,  1'b0, 12'h000, 32'd299,        32'd3},  // R7
    {RD, 4'd7,  1'b0, 12'h000, 32'd0,          32'd7},
    {WR, 4'd5,  1'b0, 12'h008, 32'd20,         32'd0},  // R5 enabled
    {RD, 4'd5,  1'b0, 12'h010, 32'd0,          32'd319},
    {RD, 4'd5,  1'b0, 12'h000, 32'd0,          32'd1},
    {WR, 4'd3,  1'b0, 12'h000, 32'd0,          32'd0},  // R3 disable
    {CN, 4'd8,  1'b0, 12'h000, 32'd1000,       32'd0},  // R8
    {RD, 4'd8,  1'b0, 12'h000, 32'd0,          32'd0},
    {WR, 4'd10, 1'b0, 12'h010, 32'd5000,       32'd0},  // R10
    {WR, 4'd10, 1'b0, 12'h014, 32'd1,          32'd0},
    {RD, 4'd10, 1'b0, 12'h010, 32'd0,          32'd5000},
    {RD, 4'd10, 1'b0, 12'h014, 32'd0,          32'd1},
    {RD, 4'd10, 1'b0, 12'h000, 32'd0,          32'd0},
    {RD, 4'd2,  1'b1, 12'h008, 32'd0,          32'd0}   // R2 unmapped
  };

  logic clk = 1'b0;
  logic porN, rstN, wrEn, rdEn, frameSel;
  logic [63:0] sysCount;
  logic [11:0] addr;
  logic [31:0] wrData, rdData;
  logic stage1Out, stage2Out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdt_top u0 (.clk(clk), .porN(porN), .rstN(rstN), .sysCount(sysCount),
    .wrEn(wrEn), .rdEn(rdEn), .frameSel(frameSel), .addr(addr),
    .wrData(wrData), .rdData(rdData), .stage1Out(stage1Out),
    .stage2Out(stage2Out));

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic fr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; frameSel = fr; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRd(input int req, input logic fr, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    rdEn = 1'b1; frameSel = fr; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    check(req, rdData, exp);
  endtask

  task automatic setCount(input int req, input logic [63:0] c, input logic [1:0] exp);
    @(negedge clk);
    sysCount = c;
    @(negedge clk);
    check(req, {30'd0, stage2Out, stage1Out}, {30'd0, exp});
  endtask

  initial begin
    porN = 0; rstN = 0; wrEn = 0; rdEn = 0; frameSel = 0;
    addr = '0; wrData = '0; sysCount = '0;
    repeat (3) @(negedge clk);
    porN = 1; rstN = 1;
    @(negedge clk);
    check(1, {30'd0, stage2Out, stage1Out}, 32'd0);  // R1 outputs after reset
    check(1, rdData, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      case (v[82:81])
        WR: busWr(v[76], v[75:64], v[63:32]);
        RD: busRd(int'(v[80:77]), v[76], v[75:64], v[31:0]);
        default: setCount(int'(v[80:77]), {32'd0, v[63:32]}, v[1:0]);
      endcase
    end

    // R9: stage-2 flag survives warm reset
    busWr(1'b0, 12'h008, 32'd20);
    busWr(1'b0, 12'h000, 32'd1);
    setCount(9, 64'd1020, 2'b01);
    setCount(9, 64'd1040, 2'b11);
    @(negedge clk); rstN = 0;
    repeat (2) @(negedge clk); rstN = 1;
    @(negedge clk);
    check(9, {30'd0, stage2Out, stage1Out}, 32'd2);
    busRd(9, 1'b0, 12'h000, 32'd4);
    setCount(9, 64'd5000, 2'b10);  // disabled after warm reset, nothing moves
    // R1: power-on reset clears it
    @(negedge clk); porN = 0;
    repeat (2) @(negedge clk); porN = 1;
    @(negedge clk);
    check(1, {30'd0, stage2Out, stage1Out}, 32'd0);
    busRd(1, 1'b0, 12'h000, 32'd0);
    busRd(1, 1'b0, 12'h008, 32'd0);
    // R6: 64-bit compare, high word matters
    busWr(1'b0, 12'h008, 32'd10);
    sysCount = 64'h1_0000_0000;
    busWr(1'b0, 12'h000, 32'd1);
    busRd(6, 1'b0, 12'h014, 32'd1);
    setCount(6, 64'h0_FFFF_FFFF, 2'b00);
    setCount(6, 64'h1_0000_000A, 2'b01);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule